// File: doc/BRIEF.md
# Power-on sequencing controller

This block sequences the start-up and shut-down of a multi-rail handset regulator. A rising edge on any of three wake pins takes it out of standby. It then enables the core, pad, analog and reference-oscillator rails together. Once the pad rail reports that it is in regulation and no fault is flagged, it counts out a release delay. When the delay ends it drives its active-low system reset high.

The host processor keeps the system alive by raising power-good. It may do so at any moment; there is no timeout. If every wake pin is released before power-good arrives, the controller falls back to standby. While power-good is high the controller is latched on. In that state wake edges have no effect, and only power-good going low can shut it down. Shut-down drops the rails in the same cycle and holds the register bank in soft reset.

After a boot in which power-good was reached, any later event that pulls reset low uses a longer release delay. Such events are a pad short, over-temperature, undervoltage or the pad rail being switched off by software. Delays are counted in prescaled ticks, so that simulation can shorten them.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: From standby, a rising edge on a wake pin sets all rail enables and moves the debug state to RAMP by the 3rd rising clock edge after the pin rises (2-flop synchronizer plus state register). Debug state encoding: STANDBY=0, RAMP=1, WAIT_PG=2, ON=3.
- R2: Each of the three bits of `wake_i` can start power-up alone, with identical timing.
- R3: `rst_no` is low while in STANDBY, and low in the same cycle whenever `pad_ok_i` is low or any bit of `fault_i` is set.
- R4: On a boot that has not yet reached ON, `rst_no` rises after exactly TICKS_100MS*PRESCALE rising edges, counted from the first edge at which the rails are on, `pad_ok_i` is high and no fault is set. The state becomes WAIT_PG one edge later.
- R5: Once ON has been reached, every later reset release takes TICKS_250MS*PRESCALE edges. Such a release follows a fault, or `pad_ok_i` dropping and returning.
- R6: In RAMP or WAIT_PG with power-good low, releasing all wake pins returns the state to STANDBY with rails off by the 3rd edge after the release.
- R7: In RAMP or WAIT_PG, `pg_i` high moves the state to ON at the next edge, whether or not reset has been released.
- R8: In ON with `pg_i` high, wake pin edges and releases leave the state, the rails and `rst_no` unchanged.
- R9: In ON, `pg_i` low clears all rail enables in the same cycle and gives STANDBY at the next edge, with `soft_rst_o` high. The next boot uses the short delay again.
- R10: `rail_en_o` bits are [0] core, [1] pad, [2] analog, [3] reference oscillator. They always switch together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_i | input | 3 | Asynchronous wake request pins |
| pg_i | input | 1 | Host power-good handshake (synchronous) |
| pad_ok_i | input | 1 | Pad rail above release threshold (synchronous) |
| fault_i | input | 4 | Fault flags: pad short, over-temperature, undervoltage, pad disabled by software |
| rail_en_o | output | 4 | Rail enables: core, pad, analog, reference oscillator |
| rst_no | output | 1 | Active-low system reset |
| soft_rst_o | output | 1 | Register bank soft reset, high in standby |
| dbg_state_o | output | 2 | Sequencer state |

## Verification
Wake-pin effects are due on the 3rd rising edge after the pin changes: two synchronizer flops, then the state register. The bench drives every input on a falling edge and counts rising edges from there, sampling one edge early and on time. Reset release is due after exactly delay times prescale edges from the moment the run condition holds. The bench samples at one edge short of that count, expecting low, and at the count, expecting high. Fault, pad-flag and power-good-low effects on `rst_no` and `rail_en_o` are combinational, so they are checked a delta after the drive. The state change they cause is checked after the next edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_RAMP    = 2'd1,
    ST_WAIT_PG = 2'd2,
    ST_ON      = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int N_PINS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_i,
  output logic              lvl_o,
  output logic              rise_o
);
  logic [N_PINS-1:0] sync_q;
  logic              lvl_prev_q;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic meta_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q    <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q    <= pins_i[g];
        sync_q[g] <= meta_q;
      end
    end
  end

  assign lvl_o = |sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= 1'b0;
    else         lvl_prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~lvl_prev_q;
endmodule

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int PRESCALE = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int T_SHORT = 100,
  parameter int T_LONG  = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic long_i,
  output logic rel_o
);
  localparam int CW = $clog2(((T_LONG > T_SHORT) ? T_LONG : T_SHORT) + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          done_q;

  assign lim = long_i ? CW'(T_LONG) : CW'(T_SHORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q == lim - CW'(1)) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // release drops in the same cycle the run condition fails
  assign rel_o = done_q & run_i;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_rise_i,
  input  logic       wake_lvl_i,
  input  logic       pg_i,
  input  logic       rel_i,
  output seq_state_e state_o,
  output logic       booted_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STANDBY: if (wake_rise_i) state_d = ST_RAMP;
      ST_RAMP, ST_WAIT_PG: begin
        if (pg_i)             state_d = ST_ON;
        else if (!wake_lvl_i) state_d = ST_STANDBY;
        else if (rel_i)       state_d = ST_WAIT_PG;
        else                  state_d = ST_RAMP;
      end
      ST_ON:      if (!pg_i) state_d = ST_STANDBY;
      default:    state_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_STANDBY;
      booted_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_ON)           booted_o <= 1'b1;
      else if (state_d == ST_STANDBY) booted_o <= 1'b0;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_WAKE      = 3,
  parameter int N_RAILS     = 4,
  parameter int N_FAULTS    = 4,
  parameter int PRESCALE    = 20000,
  parameter int TICKS_100MS = 100,
  parameter int TICKS_250MS = 250
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_WAKE-1:0]   wake_i,
  input  logic                pg_i,
  input  logic                pad_ok_i,
  input  logic [N_FAULTS-1:0] fault_i,
  output logic [N_RAILS-1:0]  rail_en_o,
  output logic                rst_no,
  output logic                soft_rst_o,
  output logic [1:0]          dbg_state_o
);
  logic       wake_lvl, wake_rise;
  logic       rails_on, run, tick, rel, booted;
  seq_state_e state;

  pwr_wake_sync #(.N_PINS(N_WAKE)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (wake_i),
    .lvl_o  (wake_lvl),
    .rise_o (wake_rise)
  );

  pwr_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_rise_i (wake_rise),
    .wake_lvl_i  (wake_lvl),
    .pg_i        (pg_i),
    .rel_i       (rel),
    .state_o     (state),
    .booted_o    (booted)
  );

  // power-good loss kills the rails without waiting for the state edge
  assign rails_on = (state != ST_STANDBY) && !((state == ST_ON) && !pg_i);
  assign run      = rails_on && pad_ok_i && !(|fault_i);

  pwr_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  pwr_rst_timer #(.T_SHORT(TICKS_100MS), .T_LONG(TICKS_250MS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .long_i (booted),
    .rel_o  (rel)
  );

  assign rail_en_o   = {N_RAILS{rails_on}};
  assign rst_no      = rel;
  assign soft_rst_o  = (state == ST_STANDBY);
  assign dbg_state_o = state;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int N_RAILS  = 4,
  parameter int N_FAULTS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pg_i,
  input logic                pad_ok_i,
  input logic [N_FAULTS-1:0] fault_i,
  input logic [N_RAILS-1:0]  rail_en_o,
  input logic                rst_no,
  input logic [1:0]          dbg_state_o
);
  localparam logic [1:0] S_STBY = 2'd0;
  localparam logic [1:0] S_RAMP = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;
  localparam logic [1:0] S_ON   = 2'd3;

  AST_RST_HELD_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pad_ok_i || (|fault_i)) |-> !rst_no);  // R3
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_state_o == S_STBY) |-> (rail_en_o == '0 && !rst_no));  // R3
  AST_PG_TO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dbg_state_o == S_RAMP || dbg_state_o == S_WAIT) && pg_i) |=> (dbg_state_o == S_ON));  // R7
  AST_ON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dbg_state_o == S_ON) && pg_i) |=> (dbg_state_o == S_ON));  // R8
  AST_PG_LOSS_RAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dbg_state_o == S_ON) && !pg_i) |-> (rail_en_o == '0));  // R9
  AST_PG_LOSS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dbg_state_o == S_ON) && !pg_i) |=> (dbg_state_o == S_STBY));  // R9
  AST_RAILS_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_en_o == '0 || rail_en_o == '1));  // R10
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N_RAILS(N_RAILS), .N_FAULTS(N_FAULTS)) u_chk (.*);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int P   = 4;
  localparam int TS  = 5;
  localparam int TL  = 12;
  localparam int SHORT_EDGES = TS * P;
  localparam int LONG_EDGES  = TL * P;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] wake = '0;
  logic       pg = 1'b0;
  logic       pad_ok = 1'b0;
  logic [3:0] fault = '0;
  logic [3:0] rail_en;
  logic       rst_n_out, soft_rst;
  logic [1:0] st;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.PRESCALE(P), .TICKS_100MS(TS), .TICKS_250MS(TL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wake_i(wake), .pg_i(pg), .pad_ok_i(pad_ok),
    .fault_i(fault), .rail_en_o(rail_en), .rst_no(rst_n_out),
    .soft_rst_o(soft_rst), .dbg_state_o(st)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // wake on one pin, ramp, release reset; optionally grab power-good
  task automatic boot(int pin, string req, bit go_on);
    wake[pin] = 1'b1;
    step(2);
    chk(req, "rails before 3rd edge", rail_en, 4'h0);
    step(1);
    chk("R1", "rails after wake", rail_en, 4'hF);
    chk("R1", "state RAMP", st, 2'd1);
    pad_ok = 1'b1;
    step(SHORT_EDGES - 1);
    chk("R4", "reset one edge early", rst_n_out, 1'b0);
    step(1);
    chk("R4", "reset released", rst_n_out, 1'b1);
    step(1);
    chk("R4", "state WAIT_PG", st, 2'd2);
    if (go_on) begin
      pg = 1'b1;
      step(1);
      chk("R7", "state ON", st, 2'd3);
    end
  endtask

  task automatic shutdown();
    wake = '0;
    pg = 1'b0;
    #1;
    chk("R9", "rails off same cycle", rail_en, 4'h0);
    chk("R9", "reset low same cycle", rst_n_out, 1'b0);
    step(1);
    chk("R9", "state STANDBY", st, 2'd0);
    chk("R9", "soft reset", soft_rst, 1'b1);
    pad_ok = 1'b0;
    step(2);
  endtask

  task automatic t_reset_state();
    chk("R3", "reset low at start", rst_n_out, 1'b0);
    chk("R1", "rails off at start", rail_en, 4'h0);
    chk("R1", "state STANDBY at start", st, 2'd0);
    pg = 1'b1;
    step(5);
    chk("R1", "pg alone does not wake", st, 2'd0);
    pg = 1'b0;
    step(1);
  endtask

  task automatic t_first_boot();
    boot(0, "R1", 1'b1);
    chk("R10", "all four rails", rail_en, 4'hF);
  endtask

  task automatic t_on_hold();
    wake[0] = 1'b0;
    step(4);
    chk("R8", "release ignored in ON", st, 2'd3);
    wake[1] = 1'b1;
    step(4);
    chk("R8", "edge ignored state", st, 2'd3);
    chk("R8", "edge ignored rails", rail_en, 4'hF);
    chk("R8", "edge ignored reset", rst_n_out, 1'b1);
    wake[1] = 1'b0;
    step(4);
    chk("R8", "release ignored reset", rst_n_out, 1'b1);
  endtask

  task automatic t_fault_long();
    fault[1] = 1'b1;
    #1;
    chk("R3", "fault pulls reset", rst_n_out, 1'b0);
    step(3);
    fault[1] = 1'b0;
    step(LONG_EDGES - 1);
    chk("R5", "long delay one early", rst_n_out, 1'b0);
    step(1);
    chk("R5", "long delay release", rst_n_out, 1'b1);
    pad_ok = 1'b0;
    #1;
    chk("R3", "pad flag pulls reset", rst_n_out, 1'b0);
    step(2);
    pad_ok = 1'b1;
    step(SHORT_EDGES);
    chk("R5", "not short delay after boot", rst_n_out, 1'b0);
    step(LONG_EDGES - SHORT_EDGES);
    chk("R5", "long delay after pad flag", rst_n_out, 1'b1);
  endtask

  task automatic t_reboot_pin2();
    boot(2, "R2", 1'b1);
    chk("R9", "short delay after shutdown", rst_n_out, 1'b1);
    shutdown();
  endtask

  task automatic t_wake_release();
    boot(1, "R2", 1'b0);
    wake[1] = 1'b0;
    step(2);
    chk("R6", "still WAIT_PG", st, 2'd2);
    step(1);
    chk("R6", "back to STANDBY", st, 2'd0);
    chk("R6", "rails off", rail_en, 4'h0);
    pad_ok = 1'b0;
    step(2);
  endtask

  task automatic t_pg_in_ramp();
    wake[0] = 1'b1;
    step(3);
    chk("R1", "RAMP before pg", st, 2'd1);
    pg = 1'b1;
    step(1);
    chk("R7", "ON from RAMP", st, 2'd3);
    chk("R7", "reset still low", rst_n_out, 1'b0);
    pad_ok = 1'b1;
    step(LONG_EDGES - 1);
    chk("R5", "long delay when booted in ON", rst_n_out, 1'b0);
    step(1);
    chk("R5", "long release", rst_n_out, 1'b1);
    shutdown();
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    t_reset_state();
    t_first_boot();
    t_on_hold();
    t_fault_long();
    shutdown();
    t_reboot_pin2();
    t_wake_release();
    t_pg_in_ramp();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule